// File: doc/BRIEF.md
# Strap-Addressed I2C Configuration Register Target

This block is an I2C target that lets an external bus controller fill and inspect a bank of 8-bit configuration registers. It watches SCL and SDA through plain input samples and pulls SDA low through a single drive-low output, so the pad itself stays open-drain. Everything runs on a system clock that oversamples the bus. Both lines pass through a two-flop synchronizer and a short agreement filter before any START, STOP or bit is decoded.

Its 7-bit bus address is picked by two strap inputs through a fixed mapping, and an enable strap turns the whole interface on or off. A write carries a one-byte register pointer followed by any number of data bytes, and the pointer advances after each byte. A read carries no pointer at all: it always returns data starting from register 00h and moves forward while the controller keeps acknowledging. The surrounding logic sees every register as a parallel output and gets a one-cycle write strobe with the address and data of each accepted write.

Top module: `i2creg_target`

## Requirements
- R1: While `en_strap` is low the block never pulls SDA low, never acknowledges, never pulses `wr_stb` and leaves every register unchanged, whatever the bus does.
- R2: The address byte (first after START, MSB first, last bit 0 = write, 1 = read) is acknowledged only when its upper seven bits equal 0x5E minus the value of `addr_sel` (00→0x5E, 01→0x5D, 10→0x5C, 11→0x5B).
- R3: In a write, the byte after the address byte is acknowledged and loaded into the register pointer.
- R4: Every later data byte of a write is acknowledged, stored at the pointer and followed by a pointer increment. Each store gives a one-cycle `wr_stb` with `wr_addr` and `wr_data`, and `reg_image` shows the new value from the next cycle on.
- R5: The pointer wraps from NUM_REGS-1 to 00h. A data byte whose pointer is NUM_REGS or more is still acknowledged but not stored and gives no strobe, and the pointer then goes to 00h.
- R6: A read returns register 00h first, MSB first, then the next register after each byte the controller acknowledges, wrapping from NUM_REGS-1 to 00h. Any pointer value set by an earlier write is not used.
- R7: When the controller answers a read byte with NACK, the block releases SDA and sends nothing more until a START or STOP. A repeated START begins a fresh address byte.
- R8: SDA is pulled low only for acknowledge bits and read data, and the drive-low output only starts while the filtered SCL is low.
- R9: After reset every register reads 00h and SDA is released.
- R10: START (SDA falling while SCL is high) and STOP (SDA rising while SCL is high) are the only framing events. After STOP the block releases SDA, and bytes clocked without a new START are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| en_strap | input | 1 | Interface enable strap |
| addr_sel | input | 2 | Target address select straps |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| sda_drive_low | output | 1 | 1 pulls SDA low through the open-drain pad |
| wr_stb | output | 1 | One-cycle pulse for each accepted register write |
| wr_addr | output | 8 | Register address of the write strobe |
| wr_data | output | 8 | Data of the write strobe |
| reg_image | output | NUM_REGS*8 | All registers, register i at bits [8i+7:8i] |

## Verification
The assertions assume the controller obeys I2C framing. SDA changes only while SCL is low, except at START and STOP. SCL edges are spaced far enough apart that the filtered SCL is low when the block updates its drive. The bench keeps to this by changing SDA only a quarter period after SCL falls, with each quarter lasting ten system clocks, and it never stretches or glitches SCL. Under these conditions the drive-low output can only rise with SCL low. The bench samples the wired-AND line in the middle of the SCL high phase, well after the synchronizer and filter delay.

// File: rtl/i2creg_pkg.sv
package i2creg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_HOLD
    } link_st_e;

    typedef enum logic [1:0] {
        NXT_SUB,
        NXT_WDATA,
        NXT_TX
    } after_ack_e;

    typedef struct packed {
        logic       stb;
        logic [7:0] addr;
        logic [7:0] data;
    } wr_req_t;

    localparam logic [6:0] BASE_ADDR = 7'h5E;

    // strap value counts the address down from the base
    function automatic logic [6:0] strap_to_addr(input logic [1:0] sel);
        return BASE_ADDR - {5'd0, sel};
    endfunction

    // pointer advance with wrap at the top of the bank
    function automatic logic [7:0] ptr_next(input logic [7:0] p, input logic [8:0] nregs);
        if ({1'b0, p} >= nregs - 9'd1) return 8'd0;
        return p + 8'd1;
    endfunction

endpackage

// File: rtl/i2creg_sync.sv
module i2creg_sync #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_f,
    output logic sda_f
);
    logic [1:0] raw_v;
    logic [1:0] filt_v;

    assign raw_v = {sda_raw, scl_raw};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [1:0]          meta_q;
        logic [FILT_LEN-1:0] win_q;
        logic                out_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 2'b11;
                win_q  <= '1;
                out_q  <= 1'b1;
            end else begin
                meta_q <= {meta_q[0], raw_v[g]};
                win_q  <= {win_q[FILT_LEN-2:0], meta_q[1]};
                if (&win_q)
                    out_q <= 1'b1;
                else if (~|win_q)
                    out_q <= 1'b0;
            end
        end

        assign filt_v[g] = out_q;
    end

    assign scl_f = filt_v[0];
    assign sda_f = filt_v[1];

endmodule

// File: rtl/i2creg_bank.sv
module i2creg_bank
    import i2creg_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  wr_req_t                 wr,
    input  logic [7:0]              rd_addr,
    output logic [7:0]              rd_data,
    output logic [NUM_REGS*8-1:0]   image
);
    localparam int         AW    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [8:0] NREG9 = 9'(NUM_REGS);

    logic [7:0] regs_q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[i] <= 8'h00;
            else if (wr.stb && wr.addr == 8'(i))
                regs_q[i] <= wr.data;
        end
        assign image[i*8 +: 8] = regs_q[i];
    end

    always_comb begin
        if ({1'b0, rd_addr} < NREG9)
            rd_data = regs_q[rd_addr[AW-1:0]];
        else
            rd_data = 8'h00;
    end

    // R4: a strobed write is visible in the bank on the next cycle
    assert_bank_update_R4: assert property (@(posedge clk) disable iff (rst)
        wr.stb |=> image[$past(wr.addr[AW-1:0])*8 +: 8] == $past(wr.data));

endmodule

// File: rtl/i2creg_link.sv
module i2creg_link
    import i2creg_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [6:0] own_addr,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_ptr,
    output wr_req_t    wr,
    output logic       sda_oe
);
    localparam logic [8:0] NREG9 = 9'(NUM_REGS);

    logic       scl_q, sda_q;
    logic       scl_rise, scl_fall, start_det, stop_det;
    link_st_e   st_q;
    after_ack_e nxt_q;
    logic [7:0] sh_q;
    logic [3:0] cnt_q;
    logic [7:0] ptr_q;
    logic [7:0] rptr_q;
    logic       mack_q;
    logic       oe_q;
    wr_req_t    wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  =  scl_f & ~scl_q;
    assign scl_fall  = ~scl_f &  scl_q;
    assign start_det =  scl_f &  scl_q &  sda_q & ~sda_f;
    assign stop_det  =  scl_f &  scl_q & ~sda_q &  sda_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            nxt_q  <= NXT_SUB;
            sh_q   <= 8'h00;
            cnt_q  <= 4'd0;
            ptr_q  <= 8'h00;
            rptr_q <= 8'h00;
            mack_q <= 1'b1;
            oe_q   <= 1'b0;
            wr_q   <= '0;
        end else begin
            wr_q.stb <= 1'b0;
            if (!en) begin
                st_q <= ST_IDLE;
                oe_q <= 1'b0;
            end else if (start_det) begin
                st_q  <= ST_ADDR;
                cnt_q <= 4'd0;
                oe_q  <= 1'b0;
            end else if (stop_det) begin
                st_q <= ST_IDLE;
                oe_q <= 1'b0;
            end else begin
                case (st_q)
                    ST_ADDR, ST_SUB, ST_WDATA: begin
                        if (scl_rise) begin
                            sh_q  <= {sh_q[6:0], sda_f};
                            cnt_q <= cnt_q + 4'd1;
                        end else if (scl_fall && cnt_q == 4'd8) begin
                            cnt_q <= 4'd0;
                            if (st_q == ST_ADDR) begin
                                if (sh_q[7:1] == own_addr) begin
                                    oe_q  <= 1'b1;
                                    st_q  <= ST_ACK;
                                    nxt_q <= sh_q[0] ? NXT_TX : NXT_SUB;
                                    if (sh_q[0]) rptr_q <= 8'h00;
                                end else begin
                                    st_q <= ST_HOLD;
                                end
                            end else if (st_q == ST_SUB) begin
                                ptr_q <= sh_q;
                                oe_q  <= 1'b1;
                                st_q  <= ST_ACK;
                                nxt_q <= NXT_WDATA;
                            end else begin
                                if ({1'b0, ptr_q} < NREG9) begin
                                    wr_q.stb  <= 1'b1;
                                    wr_q.addr <= ptr_q;
                                    wr_q.data <= sh_q;
                                end
                                ptr_q <= ptr_next(ptr_q, NREG9);
                                oe_q  <= 1'b1;
                                st_q  <= ST_ACK;
                                nxt_q <= NXT_WDATA;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt_q <= 4'd0;
                            case (nxt_q)
                                NXT_SUB: begin
                                    st_q <= ST_SUB;
                                    oe_q <= 1'b0;
                                end
                                NXT_WDATA: begin
                                    st_q <= ST_WDATA;
                                    oe_q <= 1'b0;
                                end
                                default: begin
                                    st_q <= ST_TX;
                                    sh_q <= rd_data;
                                    oe_q <= ~rd_data[7];
                                end
                            endcase
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            cnt_q <= cnt_q + 4'd1;
                        end else if (scl_fall) begin
                            if (cnt_q == 4'd8) begin
                                oe_q <= 1'b0;
                                st_q <= ST_RACK;
                            end else begin
                                oe_q <= ~sh_q[6];
                                sh_q <= {sh_q[6:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack_q <= sda_f;
                            if (!sda_f) rptr_q <= ptr_next(rptr_q, NREG9);
                        end else if (scl_fall) begin
                            cnt_q <= 4'd0;
                            if (!mack_q) begin
                                st_q <= ST_TX;
                                sh_q <= rd_data;
                                oe_q <= ~rd_data[7];
                            end else begin
                                st_q <= ST_HOLD;
                                oe_q <= 1'b0;
                            end
                        end
                    end
                    default: oe_q <= 1'b0;
                endcase
            end
        end
    end

    assign rd_ptr = rptr_q;
    assign wr     = wr_q;
    assign sda_oe = oe_q;

    // R8: the drive only begins while SCL is low
    assert_drive_on_low_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_q) |-> !scl_f);

    // R1: a low enable strap releases SDA on the next cycle
    assert_quiet_disabled_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> !oe_q && !wr_q.stb);

    // R10: a STOP releases SDA
    assert_stop_release_R10: assert property (@(posedge clk) disable iff (rst)
        (en && stop_det) |=> !oe_q);

    // R5: strobes only name implemented registers
    assert_wr_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        wr_q.stb |-> ({1'b0, wr_q.addr} < NREG9));

    // R6: the read pointer never leaves the bank
    assert_rptr_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, rptr_q} < NREG9));

endmodule

// File: rtl/i2creg_target.sv
module i2creg_target
    import i2creg_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int FILT_LEN = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en_strap,
    input  logic [1:0]            addr_sel,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_drive_low,
    output logic                  wr_stb,
    output logic [7:0]            wr_addr,
    output logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] reg_image
);
    logic       scl_f, sda_f;
    logic [7:0] rd_ptr, rd_data;
    wr_req_t    wr;

    i2creg_sync #(.FILT_LEN(FILT_LEN)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .scl_f   (scl_f),
        .sda_f   (sda_f)
    );

    i2creg_link #(.NUM_REGS(NUM_REGS)) u_link (
        .clk      (clk),
        .rst      (rst),
        .en       (en_strap),
        .own_addr (strap_to_addr(addr_sel)),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .rd_data  (rd_data),
        .rd_ptr   (rd_ptr),
        .wr       (wr),
        .sda_oe   (sda_drive_low)
    );

    i2creg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd_addr (rd_ptr),
        .rd_data (rd_data),
        .image   (reg_image)
    );

    assign wr_stb  = wr.stb;
    assign wr_addr = wr.addr;
    assign wr_data = wr.data;

endmodule

// File: tb/tb_i2creg_target.sv
module tb_i2creg_target;
    localparam int N = 32;

    logic clk = 1'b0;
    logic rst, en, scl_m, sda_m;
    logic [1:0] sel;
    logic drive, wr_stb;
    logic [7:0] wr_addr, wr_data;
    logic [N*8-1:0] image;
    logic sda_line;

    assign sda_line = sda_m & ~drive;

    always #4 clk = ~clk;

    i2creg_target #(.NUM_REGS(N), .FILT_LEN(3)) dut (
        .clk(clk), .rst(rst), .en_strap(en), .addr_sel(sel),
        .scl_in(scl_m), .sda_in(sda_line), .sda_drive_low(drive),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .reg_image(image)
    );

    int total = 0;
    int bad = 0;
    int stb_count = 0;
    bit drove_off = 0;
    bit drove_scl_high = 0;
    logic drive_prev = 1'b0;
    logic [7:0] model [N];

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_stb) stb_count++;
            if (!en && drive) drove_off = 1;
            if (drive && !drive_prev && scl_m) drove_scl_high = 1;
            drive_prev = drive;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic q();
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
    endtask

    task automatic bit_x(input logic b, output logic r);
        sda_m = b; q(); scl_m = 1'b1; q(); r = sda_line; q(); scl_m = 1'b0; q();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_x(b[i], r);
        bit_x(1'b1, r);
        ack = !r;
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] d);
        logic r;
        for (int i = 0; i < 8; i++) begin
            bit_x(1'b1, r);
            d = {d[6:0], r};
        end
        bit_x(!ack, r);
    endtask

    function automatic bit image_ok();
        for (int i = 0; i < N; i++)
            if (image[i*8 +: 8] !== model[i]) return 0;
        return 1;
    endfunction

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        bit ack;
        logic [7:0] d;
        int base;
        logic [7:0] ptr;

        rst = 1'b1; en = 1'b1; sel = 2'd0; scl_m = 1'b1; sda_m = 1'b1;
        for (int i = 0; i < N; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        q();

        // R9: reset state
        check(drive == 1'b0, "R9 sda released", drive, 0);
        check(image_ok(), "R9 registers zero", image[7:0], 0);

        // R2: address sweep for every strap value
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            for (int a = 8'h58; a <= 8'h5F; a++) begin
                bus_start();
                send_byte({7'(a), 1'b0}, ack);
                bus_stop();
                check(ack == (a == (8'h5E - s)), "R2 address match", ack, a == (8'h5E - s));
            end
        end

        sel = 2'd2;
        // R3 R4: write the full bank starting at 0
        base = stb_count;
        bus_start();
        send_byte({7'h5C, 1'b0}, ack);
        check(ack, "R2 write address ack", ack, 1);
        send_byte(8'h00, ack);
        check(ack, "R3 sub-address ack", ack, 1);
        for (int i = 0; i < N; i++) begin
            d = 8'((i * 37 + 5) & 255);
            send_byte(d, ack);
            model[i] = d;
            check(ack, "R4 data ack", ack, 1);
        end
        bus_stop();
        check(stb_count - base == N, "R4 strobe count", stb_count - base, N);
        check(image_ok(), "R4 bank contents", image[15:8], model[1]);

        // R5: pointer wrap during a write
        base = stb_count;
        bus_start();
        send_byte({7'h5C, 1'b0}, ack);
        send_byte(8'h1E, ack);
        ptr = 8'h1E;
        for (int i = 0; i < 3; i++) begin
            d = 8'hA1 + 8'(i);
            send_byte(d, ack);
            model[ptr] = d;
            ptr = (ptr == 8'(N - 1)) ? 8'h00 : ptr + 8'h01;
        end
        bus_stop();
        check(image_ok(), "R5 write wrap", image[7:0], model[0]);
        check(stb_count - base == 3, "R5 wrap strobes", stb_count - base, 3);

        // R5: out-of-range pointer drops the byte then goes to 00h
        base = stb_count;
        bus_start();
        send_byte({7'h5C, 1'b0}, ack);
        send_byte(8'h40, ack);
        send_byte(8'h77, ack);
        check(ack, "R5 out-of-range byte acked", ack, 1);
        send_byte(8'h66, ack);
        model[0] = 8'h66;
        bus_stop();
        check(stb_count - base == 1, "R5 dropped strobe", stb_count - base, 1);
        check(image_ok(), "R5 out-of-range contents", image[7:0], 8'h66);

        // R6: read from 00h through the wrap
        bus_start();
        send_byte({7'h5C, 1'b1}, ack);
        check(ack, "R2 read address ack", ack, 1);
        for (int i = 0; i <= N; i++) begin
            recv_byte(i != N, d);
            check(d == model[i % N], "R6 read data", d, model[i % N]);
        end
        bus_stop();

        // R7: after NACK the line stays released
        bus_start();
        send_byte({7'h5C, 1'b1}, ack);
        recv_byte(1'b0, d);
        recv_byte(1'b0, d);
        check(d == 8'hFF, "R7 silent after NACK", d, 8'hFF);
        bus_stop();

        // R7 R6: repeated START, read ignores the written pointer
        bus_start();
        send_byte({7'h5C, 1'b0}, ack);
        send_byte(8'h05, ack);
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
        send_byte({7'h5C, 1'b1}, ack);
        check(ack, "R7 repeated start ack", ack, 1);
        recv_byte(1'b0, d);
        check(d == model[0], "R6 read starts at 00h", d, model[0]);
        bus_stop();

        // R1: disabled strap ignores everything
        en = 1'b0;
        base = stb_count;
        bus_start();
        send_byte({7'h5C, 1'b0}, ack);
        check(!ack, "R1 no ack when disabled", ack, 0);
        send_byte(8'h02, ack);
        send_byte(8'hEE, ack);
        bus_stop();
        check(stb_count == base, "R1 no strobe", stb_count - base, 0);
        check(image_ok(), "R1 bank unchanged", image[23:16], model[2]);
        check(!drove_off, "R1 sda never driven", drove_off, 0);
        en = 1'b1;
        q();

        // R10: bytes after STOP without START are not acked
        scl_m = 1'b0; q();
        send_byte({7'h5C, 1'b0}, ack);
        check(!ack, "R10 no ack without START", ack, 0);
        bus_stop();
        check(drive == 1'b0, "R10 released after STOP", drive, 0);

        // R8: drive only begins while SCL low
        check(!drove_scl_high, "R8 drive during SCL low", drove_scl_high, 0);

        summary();
    end
endmodule